// File: doc/BRIEF.md
# Microcoded Accumulator Control Engine

This block runs a 16-bit accumulator machine under horizontal microcode. A 128-word control store supplies one 20-bit microword per clock. Each microword carries three 3-bit operation codes, a 2-bit condition select, a 2-bit next-address mode and a 7-bit target address. Each operation code is decoded on its own into eight one-hot strobes. The strobes move data among the accumulator (AC), data register (DR), address register (AR) and program counter (PC), and into and out of an internal word memory. A sequencer picks the next control address from one of four sources: the incremented address, the target field, a single return register, or an opcode map.

The control store has fixed contents. The instruction-fetch routine sits at words 64–66 and the indirect-address subroutine at words 67–68. The routines for opcodes 0–3 start at words 0, 4, 8 and 12. Every other word is an unconditional jump back to word 64, so a stray control address falls back into fetch. A load port fills main memory, normally while reset is held. A registered peek port reads main memory back, and AC, PC and the control address are brought out as registered outputs.

Top module: `ucu_engine`

## Requirements
- R1: While `rst` is high, the engine sets the control address to 64 and sets PC, AC, DR and AR to 0.
- R2: Fetch takes three cycles. The first loads AR from PC. The second loads DR from memory at AR and adds 1 to PC. The third loads AR from DR bits 10:0 and jumps to control address {0, DR[14:11], 00}, so opcode k starts at word 4·k.
- R3: When bit 15 of the instruction word is 1, the routines for opcodes 0, 2 and 3 call words 67–68 before touching the operand. The taken branch of opcode 1 also makes this call. The call replaces AR with bits 10:0 of memory at AR and then returns. This adds two cycles.
- R4: Opcode 0 (ADD) sets AC to AC plus memory at the effective address, modulo 2^16. It returns to word 64 three cycles after the map, or five with indirection.
- R5: Opcode 1 (BRANCH) loads PC with the effective address when AC bit 15 is 1. It takes three cycles, or five with indirection. When AC bit 15 is 0 it leaves PC unchanged and takes two cycles.
- R6: Opcode 2 (STORE) writes AC to memory at the effective address and leaves AC unchanged. It takes three cycles, or five with indirection.
- R7: Opcode 3 (EXCHANGE) reads the operand into DR, then swaps AC and DR in one microword, then writes the old AC to the effective address. It takes four cycles, or six with indirection.
- R8: A control word that no routine uses is an unconditional jump to word 64. Opcodes 4–15 therefore return to fetch one cycle after the map, with AC, PC and memory unchanged.
- R9: The first operation code loads AR from DR bits 10:0 when it is 101 and from PC when it is 110. Code 000 in any of the three operation fields does nothing.
- R10: A call with a true condition stores the incremented control address in the return register and jumps to the target field. A return loads the control address from the return register.
- R11: When `ld_en` is high, `ld_data` is written into memory at `ld_addr`. `peek_data` shows memory at `peek_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Memory load strobe |
| ld_addr | input | MEM_AW | Memory load address |
| ld_data | input | 16 | Memory load data |
| peek_addr | input | MEM_AW | Memory read-back address |
| peek_data | output | 16 | Registered memory read-back data |
| ac | output | 16 | Accumulator |
| pc | output | 11 | Program counter |
| car | output | 7 | Control address register |

## Verification
Each instruction is due a fixed number of clocks after reset is released. The first ADD ends after six clocks. The next instruction ends after three fetch clocks plus the routine length given in R4–R8, with two more when indirection applies. The bench counts exactly that many clocks and samples on the falling edge that follows. There the control address must be 64, which checks the cycle count, and AC and PC must hold their expected values. The operand word is read back through the peek port one clock later, since that port carries one register stage.

// File: rtl/ucu_pkg.sv
package ucu_pkg;
  localparam int CA_W   = 7;
  localparam int WORD_W = 16;
  localparam int PA_W   = 11;
  localparam int OPC_W  = 4;
  localparam logic [CA_W-1:0] FETCH_AT = 7'd64;
  localparam logic [CA_W-1:0] INDIR_AT = 7'd67;

  typedef enum logic [1:0] {NX_JMP = 2'd0, NX_CALL = 2'd1, NX_RET = 2'd2, NX_MAP = 2'd3} nxmode_e;
  typedef enum logic [1:0] {CS_ONE = 2'd0, CS_IND = 2'd1, CS_NEG = 2'd2, CS_ZERO = 2'd3} csel_e;

  typedef struct packed {
    logic [2:0]      f1;
    logic [2:0]      f2;
    logic [2:0]      f3;
    csel_e           cd;
    nxmode_e         br;
    logic [CA_W-1:0] ad;
  } uword_t;

  // first field strobes
  localparam int A_ADD = 1, A_CLR = 2, A_INCAC = 3, A_DR2AC = 4, A_DR2AR = 5, A_PC2AR = 6, A_WR = 7;
  // second field strobes
  localparam int B_SUB = 1, B_OR = 2, B_AND = 3, B_RD = 4, B_AC2DR = 5, B_INCDR = 6, B_PC2DR = 7;
  // third field strobes
  localparam int C_XOR = 1, C_COM = 2, C_SHL = 3, C_SHR = 4, C_INCPC = 5, C_AR2PC = 6;

  function automatic uword_t mk(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c,
                                input csel_e cs, input nxmode_e nm, input logic [CA_W-1:0] t);
    uword_t w;
    w.f1 = a; w.f2 = b; w.f3 = c; w.cd = cs; w.br = nm; w.ad = t;
    return w;
  endfunction
endpackage

// File: rtl/ucu_ctrl_store.sv
module ucu_ctrl_store
  import ucu_pkg::*;
(
  input  logic [CA_W-1:0] addr,
  output uword_t          word
);
  always_comb begin
    case (addr)
      // opcode 0: accumulate
      7'd0:  word = mk(3'd0, 3'd0, 3'd0, CS_IND, NX_CALL, INDIR_AT);
      7'd1:  word = mk(3'd0, 3'd4, 3'd0, CS_ONE, NX_JMP, 7'd2);
      7'd2:  word = mk(3'd1, 3'd0, 3'd0, CS_ONE, NX_JMP, FETCH_AT);
      // opcode 1: branch on negative
      7'd4:  word = mk(3'd0, 3'd0, 3'd0, CS_NEG, NX_JMP, 7'd6);
      7'd5:  word = mk(3'd0, 3'd0, 3'd0, CS_ONE, NX_JMP, FETCH_AT);
      7'd6:  word = mk(3'd0, 3'd0, 3'd0, CS_IND, NX_CALL, INDIR_AT);
      7'd7:  word = mk(3'd0, 3'd0, 3'd6, CS_ONE, NX_JMP, FETCH_AT);
      // opcode 2: store
      7'd8:  word = mk(3'd0, 3'd0, 3'd0, CS_IND, NX_CALL, INDIR_AT);
      7'd9:  word = mk(3'd0, 3'd5, 3'd0, CS_ONE, NX_JMP, 7'd10);
      7'd10: word = mk(3'd7, 3'd0, 3'd0, CS_ONE, NX_JMP, FETCH_AT);
      // opcode 3: swap with memory
      7'd12: word = mk(3'd0, 3'd0, 3'd0, CS_IND, NX_CALL, INDIR_AT);
      7'd13: word = mk(3'd0, 3'd4, 3'd0, CS_ONE, NX_JMP, 7'd14);
      7'd14: word = mk(3'd4, 3'd5, 3'd0, CS_ONE, NX_JMP, 7'd15);
      7'd15: word = mk(3'd7, 3'd0, 3'd0, CS_ONE, NX_JMP, FETCH_AT);
      // fetch
      7'd64: word = mk(3'd6, 3'd0, 3'd0, CS_ONE, NX_JMP, 7'd65);
      7'd65: word = mk(3'd0, 3'd4, 3'd5, CS_ONE, NX_JMP, 7'd66);
      7'd66: word = mk(3'd5, 3'd0, 3'd0, CS_ONE, NX_MAP, 7'd0);
      // indirect subroutine
      7'd67: word = mk(3'd0, 3'd4, 3'd0, CS_ONE, NX_JMP, 7'd68);
      7'd68: word = mk(3'd5, 3'd0, 3'd0, CS_ONE, NX_RET, 7'd0);
      default: word = mk(3'd0, 3'd0, 3'd0, CS_ONE, NX_JMP, FETCH_AT);
    endcase
  end
endmodule

// File: rtl/ucu_sequencer.sv
module ucu_sequencer
  import ucu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  csel_e            cd,
  input  nxmode_e          br,
  input  logic [CA_W-1:0]  ad,
  input  logic             st_ind,
  input  logic             st_neg,
  input  logic             st_zero,
  input  logic [OPC_W-1:0] opcode,
  output logic [CA_W-1:0]  car
);
  localparam int PAD_HI = CA_W - OPC_W - 2;

  logic [CA_W-1:0] sbr, inc, nxt;
  logic            tst, sbr_ld;

  always_comb begin
    case (cd)
      CS_ONE:  tst = 1'b1;
      CS_IND:  tst = st_ind;
      CS_NEG:  tst = st_neg;
      default: tst = st_zero;
    endcase
  end

  assign inc = car + 1'b1;

  always_comb begin
    sbr_ld = 1'b0;
    case (br)
      NX_JMP:  nxt = tst ? ad : inc;
      NX_CALL: begin
        nxt    = tst ? ad : inc;
        sbr_ld = tst;
      end
      NX_RET:  nxt = sbr;
      default: nxt = {{PAD_HI{1'b0}}, opcode, 2'b00};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car <= FETCH_AT;
      sbr <= '0;
    end else begin
      car <= nxt;
      if (sbr_ld) sbr <= inc;
    end
  end

  AST_MAP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (br == NX_MAP) |=> (car == {{PAD_HI{1'b0}}, $past(opcode), 2'b00})); // R2
  AST_CALL_SAVE: assert property (@(posedge clk) disable iff (rst)
    (br == NX_CALL && cd == CS_IND && st_ind) |=> (sbr == $past(car) + 1'b1 && car == $past(ad))); // R10
  AST_RET_LOAD: assert property (@(posedge clk) disable iff (rst)
    (br == NX_RET) |=> (car == $past(sbr))); // R10
endmodule

// File: rtl/ucu_dec3.sv
module ucu_dec3 (
  input  logic [2:0] code,
  output logic [7:0] hot
);
  always_comb begin
    hot = '0;
    hot[code] = 1'b1;
  end
endmodule

// File: rtl/ucu_datapath.sv
module ucu_datapath
  import ucu_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        f1,
  input  logic [2:0]        f2,
  input  logic [2:0]        f3,
  input  logic              ld_en,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [MEM_AW-1:0] peek_addr,
  output logic [WORD_W-1:0] peek_data,
  output logic [WORD_W-1:0] ac,
  output logic [PA_W-1:0]   pc,
  output logic              st_ind,
  output logic              st_neg,
  output logic              st_zero,
  output logic [OPC_W-1:0]  opcode
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] dr, rd_word;
  logic [PA_W-1:0]   ar, ar_src;
  logic              ar_ld;
  logic [2:0]        fld [3];
  logic [7:0]        hot [3];

  assign fld[0] = f1;
  assign fld[1] = f2;
  assign fld[2] = f3;

  for (genvar g = 0; g < 3; g++) begin : g_dec
    ucu_dec3 u_dec (.code(fld[g]), .hot(hot[g]));
  end

  assign rd_word = mem[ar[MEM_AW-1:0]];

  // AR input mux: DR address bits when strobe 5 is up, PC otherwise
  assign ar_ld  = hot[0][A_DR2AR] | hot[0][A_PC2AR];
  assign ar_src = hot[0][A_DR2AR] ? dr[PA_W-1:0] : pc;

  always_ff @(posedge clk) begin
    if (ld_en)             mem[ld_addr] <= ld_data;
    else if (hot[0][A_WR]) mem[ar[MEM_AW-1:0]] <= dr;
    peek_data <= mem[peek_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ac <= '0;
      dr <= '0;
      ar <= '0;
      pc <= '0;
    end else begin
      if (ar_ld) ar <= ar_src;

      if      (hot[0][A_ADD])   ac <= ac + dr;
      else if (hot[0][A_CLR])   ac <= '0;
      else if (hot[0][A_INCAC]) ac <= ac + 1'b1;
      else if (hot[0][A_DR2AC]) ac <= dr;
      else if (hot[1][B_SUB])   ac <= ac - dr;
      else if (hot[1][B_OR])    ac <= ac | dr;
      else if (hot[1][B_AND])   ac <= ac & dr;
      else if (hot[2][C_XOR])   ac <= ac ^ dr;
      else if (hot[2][C_COM])   ac <= ~ac;
      else if (hot[2][C_SHL])   ac <= {ac[WORD_W-2:0], 1'b0};
      else if (hot[2][C_SHR])   ac <= {1'b0, ac[WORD_W-1:1]};

      if      (hot[1][B_RD])    dr <= rd_word;
      else if (hot[1][B_AC2DR]) dr <= ac;
      else if (hot[1][B_INCDR]) dr <= dr + 1'b1;
      else if (hot[1][B_PC2DR]) dr <= {dr[WORD_W-1:PA_W], pc};

      if      (hot[2][C_INCPC]) pc <= pc + 1'b1;
      else if (hot[2][C_AR2PC]) pc <= ar;
    end
  end

  assign st_ind  = dr[WORD_W-1];
  assign st_neg  = ac[WORD_W-1];
  assign st_zero = (ac == '0);
  assign opcode  = dr[WORD_W-2 -: OPC_W];

  AST_AR_FROM_DR: assert property (@(posedge clk) disable iff (rst)
    (f1 == 3'b101) |=> (ar == $past(dr[PA_W-1:0]))); // R9
  AST_AR_FROM_PC: assert property (@(posedge clk) disable iff (rst)
    (f1 == 3'b110) |=> (ar == $past(pc))); // R9
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (f3 == 3'b101) |=> (pc == $past(pc) + 1'b1)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (f1 == 3'b000 && f2 == 3'b000 && f3 == 3'b000) |=> ($stable(ac) && $stable(pc))); // R9
endmodule

// File: rtl/ucu_engine.sv
module ucu_engine
  import ucu_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [15:0]       ld_data,
  input  logic [MEM_AW-1:0] peek_addr,
  output logic [15:0]       peek_data,
  output logic [15:0]       ac,
  output logic [10:0]       pc,
  output logic [6:0]        car
);
  uword_t           uw;
  logic             st_ind, st_neg, st_zero;
  logic [OPC_W-1:0] opcode;

  ucu_ctrl_store u_cs (.addr(car), .word(uw));

  ucu_sequencer u_seq (
    .clk(clk), .rst(rst), .cd(uw.cd), .br(uw.br), .ad(uw.ad),
    .st_ind(st_ind), .st_neg(st_neg), .st_zero(st_zero), .opcode(opcode), .car(car)
  );

  ucu_datapath #(.MEM_AW(MEM_AW)) u_dp (
    .clk(clk), .rst(rst), .f1(uw.f1), .f2(uw.f2), .f3(uw.f3),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .peek_addr(peek_addr), .peek_data(peek_data),
    .ac(ac), .pc(pc), .st_ind(st_ind), .st_neg(st_neg), .st_zero(st_zero), .opcode(opcode)
  );

  AST_RESET_FETCH: assert property (@(posedge clk)
    $fell(rst) |-> (car == FETCH_AT && pc == '0 && ac == '0)); // R1
  AST_SPARE_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    ((car == 7'd3) || (car == 7'd11) || (car > 7'd15 && car < FETCH_AT) || (car > 7'd68))
    |=> (car == FETCH_AT)); // R8
endmodule

// File: tb/tb_ucu_engine.sv
module tb_ucu_engine;
  localparam int MEM_AW = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ld_en = 1'b0;
  logic [MEM_AW-1:0] ld_addr = '0;
  logic [15:0]       ld_data = '0;
  logic [MEM_AW-1:0] peek_addr = '0;
  logic [15:0]       peek_data, ac;
  logic [10:0]       pc;
  logic [6:0]        car;

  int n_chk = 0;
  int n_bad = 0;

  ucu_engine #(.MEM_AW(MEM_AW)) dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .peek_addr(peek_addr), .peek_data(peek_data), .ac(ac), .pc(pc), .car(car)
  );

  always #5 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [MEM_AW-1:0] a, input logic [15:0] d);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    step(1);
    ld_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [15:0] av [6];
    logic [15:0] mv [3];
    av[0] = 16'h0000; av[1] = 16'h7FFF; av[2] = 16'h8000;
    av[3] = 16'hFFFF; av[4] = 16'h1234; av[5] = 16'hA5C3;
    mv[0] = 16'h0001; mv[1] = 16'hFFFF; mv[2] = 16'h5A5A;

    step(2);
    chk("R1", "car", int'(car), 64);
    chk("R1", "pc", int'(pc), 0);
    chk("R1", "ac", int'(ac), 0);

    for (int opc = 0; opc < 16; opc++) begin
      for (int ind = 0; ind < 2; ind++) begin
        for (int ia = 0; ia < 6; ia++) begin
          for (int im = 0; im < 3; im++) begin
            logic [15:0] a, m, exp_ac, exp_m;
            logic [10:0] exp_pc;
            int n2;
            a = av[ia]; m = mv[im];
            rst = 1'b1;
            load(8'd0, {1'b0, 4'd0, 11'd100});
            load(8'd1, {ind[0], opc[3:0], (ind != 0) ? 11'd101 : 11'd102});
            load(8'd100, a);
            load(8'd101, 16'd102);
            load(8'd102, m);
            rst = 1'b0;
            // R2 fetch (3) + R4 direct ADD (3)
            step(6);
            chk("R2", "car after first ADD", int'(car), 64);
            chk("R4", "ac after first ADD", int'(ac), int'(a));

            exp_ac = a; exp_pc = 11'd2; exp_m = m;
            case (opc)
              0: begin n2 = 3 + 3 + 2 * ind; exp_ac = a + m; end                          // R4 R3
              1: begin                                                                    // R5
                if (a[15]) begin n2 = 3 + 3 + 2 * ind; exp_pc = 11'd102; end
                else n2 = 3 + 2;
              end
              2: begin n2 = 3 + 3 + 2 * ind; exp_m = a; end                               // R6
              3: begin n2 = 3 + 4 + 2 * ind; exp_ac = m; exp_m = a; end                   // R7
              default: n2 = 3 + 1;                                                        // R8
            endcase
            step(n2);
            chk((opc == 0) ? "R4" : (opc == 1) ? "R5" : (opc == 2) ? "R6" : (opc == 3) ? "R7" : "R8",
                "car at boundary", int'(car), 64);
            chk((ind != 0) ? "R3" : "R2", "ac", int'(ac), int'(exp_ac));
            chk((opc == 1) ? "R5" : "R8", "pc", int'(pc), int'(exp_pc));
            peek_addr = 8'd102;
            step(1);
            chk((opc == 2) ? "R6" : (opc == 3) ? "R7" : "R11", "mem[102]", int'(peek_data), int'(exp_m));
          end
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule